// File: doc/BRIEF.md
# Octet Destuffing Frame Receiver

This block takes bytes arriving from a line and recovers the bodies of the frames they carry. A reserved delimiter octet, 0x7E, separates frames. An escape octet, 0x7D, followed by a second octet stands for one data byte whose value is the second octet XOR 0x20. The receiver removes these escapes, drops runs of delimiters that enclose nothing, and passes each frame body on as a byte stream. The trailing check octets stay in the stream because a downstream stage verifies them. The final byte of a body carries an end marker and a single error indication for the whole frame.

The end of a body is known only when the closing delimiter arrives, so the block always holds one decoded byte back. It releases that byte when the next decoded byte arrives, or releases it with the end marker when the closing delimiter arrives. A delimiter closes one frame and also opens the next. Bytes that arrive before the first delimiter after reset belong to no frame and are dropped. A bad escape, an escape cut short by a delimiter, or a body shorter than the check field plus one octet marks the frame as faulty.

Top module: `frame_unstuffer`

## Requirements
- R1: After reset, every byte before the first 0x7E is dropped and produces no output. That first 0x7E opens a frame.
- R2: Inside a frame, the received pair 0x7D, 0x5E produces the single data byte 0x7E.
- R3: Inside a frame, the received pair 0x7D, 0x5D produces the single data byte 0x7D.
- R4: Any other byte inside a frame, other than 0x7E or 0x7D, is delivered unchanged, and body bytes keep their order.
- R5: A 0x7E that directly follows another 0x7E produces no output. It closes the empty frame and opens a new one.
- R6: Body byte k appears on the output, with out_valid high, in the clock after the next body byte or the closing 0x7E is accepted. out_last is high only on the final body byte, in the clock after the closing 0x7E is accepted.
- R7: A 0x7D followed by a byte other than 0x5E, 0x5D or 0x7E still yields one data byte, equal to that byte XOR 0x20. The frame is reported with out_err = 1.
- R8: A 0x7D followed directly by 0x7E aborts the frame. Bytes already decoded are delivered, and the last of them carries out_last = 1 and out_err = 1.
- R9: A body of fewer than FCS_BYTES + 1 decoded bytes (5 by default) ends with out_err = 1. A body of exactly 5 bytes with no escape fault ends with out_err = 0.
- R10: out_valid is low during and right after reset. out_err is high only together with out_valid and out_last.
- R11: A cycle with in_valid low changes no state, and in the next clock out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A line byte is present on in_byte this cycle |
| in_byte | input | 8 | Received line byte |
| out_valid | output | 1 | A decoded body byte is present on out_byte |
| out_byte | output | 8 | Decoded body byte |
| out_last | output | 1 | Marks the final byte of a body |
| out_err | output | 1 | Frame fault (bad escape, abort or short body), valid with out_last |

## Verification
On every clock, the assertions check the framing relations between the ports. The error flag appears only on a final byte. A final byte always follows an accepted delimiter. An idle input cycle leaves the output quiet. Nothing leaves the block while it waits for its first delimiter. They also check that each escape is resolved by the very next byte, and that a frame never closes without a held byte. The scoreboard scenarios are needed to show which byte values come out, the one-byte hold-back, the length boundary at five octets, and that a delimiter shared between two frames ends the first frame and opens the second.

// File: rtl/unstuff_pkg.sv
package unstuff_pkg;

   localparam int OCTET_W = 8;

   typedef enum logic {
      MODE_HUNT = 1'b0,
      MODE_BODY = 1'b1
   } rx_mode_e;

   typedef struct packed {
      logic               is_flag;
      logic               is_esc;
      logic               esc_ok;
      logic [OCTET_W-1:0] restored;
   } octet_class_t;

endpackage

// File: rtl/unstuff_classify.sv
module unstuff_classify
   import unstuff_pkg::*;
#(
   parameter logic [OCTET_W-1:0] FLAG_OCTET = 8'h7E,
   parameter logic [OCTET_W-1:0] ESC_OCTET  = 8'h7D,
   parameter logic [OCTET_W-1:0] FLIP_MASK  = 8'h20
) (
   input  logic [OCTET_W-1:0] octet,
   output octet_class_t       cls
);

   localparam logic [OCTET_W-1:0] FLAG_ALIAS = FLAG_OCTET ^ FLIP_MASK;
   localparam logic [OCTET_W-1:0] ESC_ALIAS  = ESC_OCTET ^ FLIP_MASK;

   always_comb begin
      cls.is_flag  = (octet == FLAG_OCTET);
      cls.is_esc   = (octet == ESC_OCTET);
      cls.esc_ok   = (octet == FLAG_ALIAS) || (octet == ESC_ALIAS);
      cls.restored = octet ^ FLIP_MASK;
   end

endmodule

// File: rtl/unstuff_tracker.sv
module unstuff_tracker
   import unstuff_pkg::*;
#(
   parameter int MIN_BODY = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [OCTET_W-1:0] in_byte,
   input  octet_class_t       cls,
   output logic               hunting,
   output logic               dec_valid,
   output logic [OCTET_W-1:0] dec_byte,
   output logic               close_evt,
   output logic               close_err
);

   localparam int CNT_W = $clog2(MIN_BODY + 1);
   localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_BODY);

   rx_mode_e         mode_q, mode_d;
   logic             esc_q, esc_d;
   logic             ferr_q, ferr_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] cnt_inc;

   assign hunting = (mode_q == MODE_HUNT);
   assign cnt_inc = (cnt_q == MIN_CNT) ? cnt_q : cnt_q + 1'b1;

   always_comb begin
      mode_d    = mode_q;
      esc_d     = esc_q;
      ferr_d    = ferr_q;
      cnt_d     = cnt_q;
      dec_valid = 1'b0;
      dec_byte  = in_byte;
      close_evt = 1'b0;
      close_err = ferr_q | esc_q | (cnt_q < MIN_CNT);
      if (in_valid) begin
         if (mode_q == MODE_HUNT) begin
            if (cls.is_flag) mode_d = MODE_BODY;
         end else if (cls.is_flag) begin
            close_evt = (cnt_q != '0);
            esc_d     = 1'b0;
            ferr_d    = 1'b0;
            cnt_d     = '0;
         end else if (esc_q) begin
            dec_valid = 1'b1;
            dec_byte  = cls.restored;
            esc_d     = 1'b0;
            if (!cls.esc_ok) ferr_d = 1'b1;
            cnt_d     = cnt_inc;
         end else if (cls.is_esc) begin
            esc_d = 1'b1;
         end else begin
            dec_valid = 1'b1;
            cnt_d     = cnt_inc;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_HUNT;
         esc_q  <= 1'b0;
         ferr_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         mode_q <= mode_d;
         esc_q  <= esc_d;
         ferr_q <= ferr_d;
         cnt_q  <= cnt_d;
      end
   end

   // R7 / R8: a pending escape is always resolved by the next accepted byte
   assert_escape_resolves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (esc_q && in_valid) |=> !esc_q);

   // R11: idle input leaves frame state untouched
   assert_idle_holds_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(cnt_q) && $stable(esc_q) && $stable(ferr_q)));

endmodule

// File: rtl/unstuff_holdback.sv
module unstuff_holdback
   import unstuff_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dec_valid,
   input  logic [OCTET_W-1:0] dec_byte,
   input  logic               close_evt,
   input  logic               close_err,
   output logic               out_valid,
   output logic [OCTET_W-1:0] out_byte,
   output logic               out_last,
   output logic               out_err
);

   logic               held_q;
   logic [OCTET_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q    <= 1'b0;
         hold_q    <= '0;
         out_valid <= 1'b0;
         out_byte  <= '0;
         out_last  <= 1'b0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_err   <= 1'b0;
         if (close_evt) begin
            out_valid <= held_q;
            out_byte  <= hold_q;
            out_last  <= held_q;
            out_err   <= held_q & close_err;
            held_q    <= 1'b0;
         end else if (dec_valid) begin
            out_valid <= held_q;
            out_byte  <= hold_q;
            hold_q    <= dec_byte;
            held_q    <= 1'b1;
         end
      end
   end

   // R6: a frame only closes when a body byte is waiting
   assert_close_has_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      close_evt |-> held_q);

endmodule

// File: rtl/frame_unstuffer.sv
module frame_unstuffer
   import unstuff_pkg::*;
#(
   parameter logic [7:0] FLAG_OCTET = 8'h7E,
   parameter logic [7:0] ESC_OCTET  = 8'h7D,
   parameter logic [7:0] FLIP_MASK  = 8'h20,
   parameter int         FCS_BYTES  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   output logic       out_valid,
   output logic [7:0] out_byte,
   output logic       out_last,
   output logic       out_err
);

   localparam int MIN_BODY = FCS_BYTES + 1;

   generate
      if (FCS_BYTES != 2 && FCS_BYTES != 4) begin : g_bad_fcs
         $error("frame_unstuffer: FCS_BYTES must be 2 or 4");
      end
      if (FLAG_OCTET == ESC_OCTET) begin : g_bad_codes
         $error("frame_unstuffer: delimiter and escape octets must differ");
      end
      if (FLIP_MASK == '0) begin : g_bad_mask
         $error("frame_unstuffer: escape mask must be nonzero");
      end
   endgenerate

   octet_class_t       cls;
   logic               hunting;
   logic               dec_valid;
   logic [OCTET_W-1:0] dec_byte;
   logic               close_evt;
   logic               close_err;

   unstuff_classify #(
      .FLAG_OCTET (FLAG_OCTET),
      .ESC_OCTET  (ESC_OCTET),
      .FLIP_MASK  (FLIP_MASK)
   ) u_classify (
      .octet (in_byte),
      .cls   (cls)
   );

   unstuff_tracker #(
      .MIN_BODY (MIN_BODY)
   ) u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .cls       (cls),
      .hunting   (hunting),
      .dec_valid (dec_valid),
      .dec_byte  (dec_byte),
      .close_evt (close_evt),
      .close_err (close_err)
   );

   unstuff_holdback u_holdback (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec_valid (dec_valid),
      .dec_byte  (dec_byte),
      .close_evt (close_evt),
      .close_err (close_err),
      .out_valid (out_valid),
      .out_byte  (out_byte),
      .out_last  (out_last),
      .out_err   (out_err)
   );

   // R10: error indication only rides on a final byte
   assert_err_with_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_valid && out_last));

   // R11: an idle input cycle yields no output in the following clock
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R6: a final byte is emitted only after a delimiter was accepted
   assert_last_after_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> $past(in_valid && in_byte == FLAG_OCTET));

   // R1: nothing is emitted while still searching for the first delimiter
   assert_hunt_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (hunting && in_valid) |=> !out_valid);

endmodule

// File: tb/sim_frame_unstuffer.sv
module sim_frame_unstuffer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid;
   logic [7:0] out_byte;
   logic       out_last;
   logic       out_err;

   int vectors = 0;
   int misses  = 0;
   bit gap_mode = 1'b0;
   bit done = 1'b0;

   logic [9:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] body[$];

   always #5 clk = ~clk;

   frame_unstuffer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .out_valid (out_valid),
      .out_byte  (out_byte),
      .out_last  (out_last),
      .out_err   (out_err)
   );

   task automatic expect_item(input logic [7:0] b, input logic last, input logic err,
                              input string tag);
      exp_q.push_back({err, last, b});
      tag_q.push_back(tag);
   endtask

   task automatic drive(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      in_byte  = 8'hxx;
      if (gap_mode) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   // Encodes the global body between two delimiters and records the expected output.
   task automatic send_frame(input string tag);
      drive(8'h7E);
      foreach (body[i]) begin
         if (body[i] == 8'h7E || body[i] == 8'h7D) begin
            drive(8'h7D);
            drive(body[i] ^ 8'h20);
         end else begin
            drive(body[i]);
         end
         expect_item(body[i], (i == body.size() - 1), (i == body.size() - 1) && (body.size() < 5), tag);
      end
      drive(8'h7E);
   endtask

   // Scoreboard monitor: samples away from the active edge.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         vectors++;
         if (exp_q.size() == 0) begin
            misses++;
            $display("FAIL R6 unexpected output: actual=%02h last=%0d err=%0d expected=none",
                     out_byte, out_last, out_err);
         end else begin
            logic [9:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({out_err, out_last, out_byte} !== e) begin
               misses++;
               $display("FAIL %s: actual byte=%02h last=%0d err=%0d expected byte=%02h last=%0d err=%0d",
                        t, out_byte, out_last, out_err, e[7:0], e[8], e[9]);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         misses++;
         vectors++;
         $display("FAIL R6 watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0) begin
         misses++;
         $display("FAIL R10 during reset: actual out_valid=%0d expected=0", out_valid);
      end
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0 || out_err !== 1'b0) begin
         misses++;
         $display("FAIL R10 after reset: actual valid=%0d err=%0d expected=0/0", out_valid, out_err);
      end

      // R1: junk before the first delimiter, including an escape octet, is dropped
      drive(8'h11);
      drive(8'h7D);
      drive(8'h22);
      // R4: plain bytes pass unchanged and in order
      body = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6};
      send_frame("R4 plain body");

      // R2 / R3 / R11: escaped delimiter and escape octets, with idle gaps between bytes
      gap_mode = 1'b1;
      body = '{8'h7E, 8'h01, 8'h7D, 8'h7D, 8'h02, 8'h7E};
      send_frame("R2 R3 R11 escaped body");
      gap_mode = 1'b0;

      // R5: runs of delimiters produce nothing
      drive(8'h7E);
      drive(8'h7E);
      drive(8'h7E);
      idle(2);

      // R9: length boundary around five octets
      body = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50};
      send_frame("R9 five-byte body");
      body = '{8'h61, 8'h62, 8'h63, 8'h64};
      send_frame("R9 four-byte body");
      body = '{8'h77};
      send_frame("R9 one-byte body");

      // R7: illegal escape value, decoded as XOR 0x20 and frame faulted
      drive(8'h7E);
      drive(8'h11); expect_item(8'h11, 1'b0, 1'b0, "R7 bad escape");
      drive(8'h22); expect_item(8'h22, 1'b0, 1'b0, "R7 bad escape");
      drive(8'h33); expect_item(8'h33, 1'b0, 1'b0, "R7 bad escape");
      drive(8'h44); expect_item(8'h44, 1'b0, 1'b0, "R7 bad escape");
      drive(8'h55); expect_item(8'h55, 1'b0, 1'b0, "R7 bad escape");
      drive(8'h7D);
      drive(8'h41); expect_item(8'h61, 1'b1, 1'b1, "R7 bad escape");
      drive(8'h7E);

      // R8: escape cut short by a delimiter; that delimiter also opens the next frame
      drive(8'h01); expect_item(8'h01, 1'b0, 1'b0, "R8 abort");
      drive(8'h02); expect_item(8'h02, 1'b0, 1'b0, "R8 abort");
      drive(8'h03); expect_item(8'h03, 1'b0, 1'b0, "R8 abort");
      drive(8'h04); expect_item(8'h04, 1'b0, 1'b0, "R8 abort");
      drive(8'h05); expect_item(8'h05, 1'b0, 1'b0, "R8 abort");
      drive(8'h06); expect_item(8'h06, 1'b1, 1'b1, "R8 abort");
      drive(8'h7D);
      drive(8'h7E);
      drive(8'h31); expect_item(8'h31, 1'b0, 1'b0, "R5 R8 shared delimiter");
      drive(8'h32); expect_item(8'h32, 1'b0, 1'b0, "R5 R8 shared delimiter");
      drive(8'h33); expect_item(8'h33, 1'b0, 1'b0, "R5 R8 shared delimiter");
      drive(8'h34); expect_item(8'h34, 1'b0, 1'b0, "R5 R8 shared delimiter");
      drive(8'h35); expect_item(8'h35, 1'b1, 1'b0, "R5 R8 shared delimiter");
      drive(8'h7E);

      // R6: hold-back visible at the ports: no output until a second byte arrives
      drive(8'h7E);
      drive(8'h99);
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0) begin
         misses++;
         $display("FAIL R6 hold-back: actual out_valid=%0d expected=0", out_valid);
      end
      drive(8'h7E);
      expect_item(8'h99, 1'b1, 1'b1, "R6 R9 single held byte");
      idle(4);

      vectors++;
      if (exp_q.size() != 0) begin
         misses++;
         $display("FAIL R6 drain: actual pending=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule